// File: doc/BRIEF.md
# Edge-Sensing Interrupt Port

This block is a byte-wide general-purpose port with eight pin positions, of which seven (positions 7 down to 1) are live. Each live pin can drive a level onto the pad or read the pad. Each live pin can also act as an external interrupt source. For each pin, software picks one of four sensing modes: active-low level, rising edge, falling edge, or either edge. Edge events latch into sticky flags, and software clears a flag by writing a one to it. Each pin has its own interrupt request line. A request is raised only while that pin's enable bit is set.

Sensing always looks at the value present on the pin, whatever the pin's direction. When a pin is an output, the sensing logic sees the port's own data latch. Software can therefore raise an interrupt by writing the data register. Requests in level mode come straight from the synchronized pin level and never pass through the flags. Every pin value passes through a two-stage synchronizer before any detection logic uses it.

Top module: `pinirq_port`

Register offsets (byte address on `reg_addr`):

| Offset | Register |
|---|---|
| 0 | Mode, pins 7..4 |
| 1 | Mode, pins 3..0 |
| 2 | Direction |
| 3 | Enable |
| 4 | Data |
| 5 | Flags |

Pin *i* owns mode bits [2i+1:2i] of the 16-bit mode word. The encodings are 00 level-low, 01 rising, 10 falling and 11 both edges.

## Requirements
- R1: After reset, direction, enable and flags read 0x00, the data latch holds all ones, `pin_out` is 0xFE, `pin_oe` is 0x00 and `irq` is 0x00.
- R2: Bit 0 is reserved in every register: it reads as 0 and ignores writes. `irq[0]`, `pin_oe[0]` and `pin_out[0]` are always 0.
- R3: A direction bit of 1 makes the pin an output. `pin_oe` follows the direction register and `pin_out` follows the data latch.
- R4: Reading offset 4 returns the data latch bit for output pins and the synchronized pad value for input pins.
- R5: In modes 01, 10 and 11, a flag bit sets on a rising, falling or either transition of the synchronized pin value, respectively. A steady pin sets no flag.
- R6: Writing 1 to a flag bit at offset 5 clears it, and writing 0 leaves it unchanged. If a configured edge and a clearing write land in the same cycle, the flag ends up set.
- R7: With its enable bit set, a pin asserts `irq` while its flag is set. This holds whether the flag was set before or after the enable.
- R8: With its enable bit set and its mode 00, a pin asserts `irq` while its synchronized level is 0, whatever its flag holds. Mode 00 never sets a flag.
- R9: Clearing an enable bit drops that pin's `irq` in the cycle right after the write.
- R10: For an output pin, a write to the data latch that makes a configured edge sets the pin's flag, so software can trigger interrupts.
- R11: The registers sit at the offsets given above, and the mode word reads back with pin 0's field forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, captured on the rising clock edge |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Levels driven toward the pads |
| pin_oe | output | 8 | Output enable per pad |
| irq | output | 8 | Interrupt request per pin |

## Verification
The assertions assume that `pin_in` is only sampled through the synchronizer. They also assume that reset is held for at least one edge before any write, so the edge history starts from known all-ones values. The stimulus changes `pin_in` and register fields only at falling clock edges and then waits longer than the synchronizer depth before judging flags and requests. The one exception is the directed collision case, which times a clearing write to land on the same edge that latches a flag. Random rounds clear the flags after each reconfiguration, so every expected flag comes from one known pad transition.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int PORT_W = 8;
    localparam int MODE_W = 2 * PORT_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_MODE_HI = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MODE_LO = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EN      = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_FLAG    = 3'd5;

    // Position 0 carries no pin.
    localparam logic [PORT_W-1:0] LIVE_MASK = 8'hFE;

    typedef enum logic [1:0] {
        SNS_LEVEL_LOW = 2'b00,
        SNS_RISE      = 2'b01,
        SNS_FALL      = 2'b10,
        SNS_BOTH      = 2'b11
    } sense_e;

    function automatic logic [MODE_W-1:0] mode_live_mask();
        logic [MODE_W-1:0] m;
        for (int i = 0; i < PORT_W; i++) begin
            m[2*i]   = LIVE_MASK[i];
            m[2*i+1] = LIVE_MASK[i];
        end
        return m;
    endfunction

    function automatic logic edge_hit(sense_e mode, logic was, logic now);
        logic h;
        case (mode)
            SNS_RISE:  h = ~was & now;
            SNS_FALL:  h = was & ~now;
            SNS_BOTH:  h = was ^ now;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int              W      = 8,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    INIT   = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) chain[s] <= INIT;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < DEPTH; s++) chain[s] <= chain[s-1];
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];

    // History stage trails the synchronized value by exactly one cycle (R5).
    p_prev_lags_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_prev == $past(q)));

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
    import pinirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] flag_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] en_q,
    output logic [PORT_W-1:0] data_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [PORT_W-1:0] clr_vec,
    output logic [7:0]        reg_rdata
);
    localparam logic [MODE_W-1:0] MODE_MASK = mode_live_mask();

    logic [PORT_W-1:0] data_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            en_q   <= '0;
            data_q <= LIVE_MASK;
            mode_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_MODE_HI: mode_q[15:8] <= reg_wdata & MODE_MASK[15:8];
                OFS_MODE_LO: mode_q[7:0]  <= reg_wdata & MODE_MASK[7:0];
                OFS_DIR:     dir_q        <= reg_wdata & LIVE_MASK;
                OFS_EN:      en_q         <= reg_wdata & LIVE_MASK;
                OFS_DATA:    data_q       <= reg_wdata & LIVE_MASK;
                default:     ;
            endcase
        end
    end

    assign clr_vec   = (reg_wr && reg_addr == OFS_FLAG) ? (reg_wdata & LIVE_MASK) : '0;
    assign data_view = ((dir_q & data_q) | (~dir_q & pin_sync)) & LIVE_MASK;

    always_comb begin
        case (reg_addr)
            OFS_MODE_HI: reg_rdata = mode_q[15:8];
            OFS_MODE_LO: reg_rdata = mode_q[7:0];
            OFS_DIR:     reg_rdata = dir_q;
            OFS_EN:      reg_rdata = en_q;
            OFS_DATA:    reg_rdata = data_view;
            OFS_FLAG:    reg_rdata = flag_q;
            default:     reg_rdata = '0;
        endcase
    end

    // Reserved position never takes a written value (R2).
    p_rsvd_regs_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dir_q[0] == 1'b0 && en_q[0] == 1'b0 && data_q[0] == 1'b0));

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
    import pinirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_q,
    input  logic [PORT_W-1:0] en_q,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] pin_prev,
    input  logic [PORT_W-1:0] clr_vec,
    output logic [PORT_W-1:0] flag_q,
    output logic [PORT_W-1:0] level_req,
    output logic [PORT_W-1:0] irq
);
    logic [PORT_W-1:0] hit_vec;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        sense_e mode_i;
        assign mode_i       = sense_e'(mode_q[2*i +: 2]);
        assign hit_vec[i]   = LIVE_MASK[i] & edge_hit(mode_i, pin_prev[i], pin_sync[i]);
        assign level_req[i] = LIVE_MASK[i] & (mode_i == SNS_LEVEL_LOW) & ~pin_sync[i];

        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= hit_vec[i] | (flag_q[i] & ~clr_vec[i]);
        end
    end

    assign irq = en_q & (flag_q | level_req) & LIVE_MASK;

    // A set flag survives any cycle without a clearing write (R6).
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flag_q) & ~$past(clr_vec)) & ~flag_q) == '0));

    // A detected edge always lands in the flag, even against a clear (R6).
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit_vec) & ~flag_q) == '0));

endmodule

// File: rtl/pinirq_port.sv
module pinirq_port
    import pinirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    output logic [7:0]  irq
);
    logic [PORT_W-1:0] dir_q, en_q, data_q, flag_q, clr_vec;
    logic [PORT_W-1:0] pad_view, pin_sync, pin_prev, level_req;
    logic [MODE_W-1:0] mode_q;

    // Sensing sees the driven level on outputs, the pad on inputs.
    assign pad_view = (dir_q & data_q) | (~dir_q & pin_in);

    pinirq_sync #(
        .W      (PORT_W),
        .STAGES (SYNC_STAGES),
        .INIT   ('1)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pad_view),
        .q      (pin_sync),
        .q_prev (pin_prev)
    );

    pinirq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .flag_q    (flag_q),
        .dir_q     (dir_q),
        .en_q      (en_q),
        .data_q    (data_q),
        .mode_q    (mode_q),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    pinirq_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .mode_q    (mode_q),
        .en_q      (en_q),
        .pin_sync  (pin_sync),
        .pin_prev  (pin_prev),
        .clr_vec   (clr_vec),
        .flag_q    (flag_q),
        .level_req (level_req),
        .irq       (irq)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    // Reserved position is silent on every output (R2).
    p_rsvd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        irq[0] == 1'b0 && pin_oe[0] == 1'b0 && pin_out[0] == 1'b0);

    // No request from a pin whose enable is clear (R7, R9).
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        (irq & ~en_q) == '0);

    // An enabled low level in level mode always requests (R8).
    p_level_req_r8: assert property (@(posedge clk) disable iff (rst)
        ((en_q & level_req) & ~irq) == '0);

endmodule

// File: tb/pinirq_port_tb_top.sv
`timescale 1ns/1ps
module pinirq_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_out, pin_oe, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [7:0] LIVE = 8'hFE;
    localparam logic [2:0] A_MHI = 3'd0, A_MLO = 3'd1, A_DIR = 3'd2,
                           A_EN = 3'd3, A_DATA = 3'd4, A_FLAG = 3'd5;

    always #10 clk = ~clk;

    pinirq_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    function automatic logic [7:0] exp_flags(logic [15:0] mode, logic [7:0] was, logic [7:0] now);
        logic [7:0] f;
        for (int i = 0; i < 8; i++) begin
            case (mode[2*i +: 2])
                2'b01:   f[i] = ~was[i] & now[i];
                2'b10:   f[i] = was[i] & ~now[i];
                2'b11:   f[i] = was[i] ^ now[i];
                default: f[i] = 1'b0;
            endcase
        end
        return f & LIVE;
    endfunction

    function automatic logic [7:0] level_mask(logic [15:0] mode);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (mode[2*i +: 2] == 2'b00);
        return m & LIVE;
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] mode;
        logic [7:0]  dir, en, dat, p, p2, eff, eff2, ef;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h0000_5EED);

        settle(3);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        check("R1", "pin_out", {8'h0, pin_out}, {8'h0, 8'hFE});
        check("R1", "pin_oe",  {8'h0, pin_oe},  16'h0);
        check("R1", "irq",     {8'h0, irq},     16'h0);
        rd(A_DIR, v);  check("R1", "dir",  {8'h0, v}, 16'h0);
        rd(A_EN, v);   check("R1", "en",   {8'h0, v}, 16'h0);
        rd(A_FLAG, v); check("R1", "flag", {8'h0, v}, 16'h0);

        // R2 reserved bit
        wr(A_DIR, 8'hFF); wr(A_EN, 8'hFF); wr(A_MLO, 8'hFF);
        rd(A_DIR, v); check("R2", "dir bit0",  {8'h0, v}, 16'h00FE);
        rd(A_EN, v);  check("R2", "en bit0",   {8'h0, v}, 16'h00FE);
        rd(A_MLO, v); check("R11", "mode lo",  {8'h0, v}, 16'h00FC);
        check("R2", "oe bit0", {15'h0, pin_oe[0]}, 16'h0);
        wr(A_DIR, 8'h00); wr(A_EN, 8'h00); wr(A_MLO, 8'h00);

        // R5/R6/R7/R9: pin1 rising, collision of edge and clear
        wr(A_MLO, 8'h04);
        @(negedge clk) pin_in[1] = 1'b0;
        settle(5);
        wr(A_FLAG, 8'hFE);
        @(negedge clk) pin_in[1] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h02;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        rd(A_FLAG, v); check("R6", "edge beats clear", {8'h0, v}, 16'h0002);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, v); check("R6", "write 0 keeps", {8'h0, v}, 16'h0002);
        wr(A_EN, 8'h02);
        #1 check("R7", "irq from flag", {8'h0, irq}, 16'h0002);
        wr(A_EN, 8'h00);
        #1 check("R9", "enable drop", {8'h0, irq}, 16'h0000);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, v); check("R6", "write 1 clears", {8'h0, v}, 16'h0000);

        // R8 level-low on pin3
        wr(A_MLO, 8'h00); wr(A_EN, 8'h08);
        @(negedge clk) pin_in[3] = 1'b0;
        settle(4);
        @(negedge clk);
        check("R8", "level irq", {8'h0, irq}, 16'h0008);
        rd(A_FLAG, v); check("R8", "level no flag", {8'h0, v}, 16'h0000);
        @(negedge clk) pin_in[3] = 1'b1;
        settle(4); @(negedge clk);
        check("R8", "level release", {8'h0, irq}, 16'h0000);
        wr(A_EN, 8'h00);

        // R10/R3 software trigger on output pin5, falling
        wr(A_MHI, 8'h08); wr(A_DIR, 8'h20); wr(A_DATA, 8'hFE);
        settle(5); wr(A_FLAG, 8'hFE);
        wr(A_DATA, 8'hDE);
        settle(5);
        rd(A_FLAG, v); check("R10", "sw trigger flag", {8'h0, v}, 16'h0020);
        check("R3", "pin_oe", {8'h0, pin_oe}, 16'h0020);
        check("R3", "pin_out", {8'h0, pin_out}, 16'h00DE);
        rd(A_MHI, v); check("R11", "mode hi", {8'h0, v}, 16'h0008);

        // Random rounds: R3 R4 R5 R7 R8
        for (int it = 0; it < 60; it++) begin
            mode = 16'($urandom) & 16'hFFFC;
            dir  = 8'($urandom) & LIVE;
            en   = 8'($urandom) & LIVE;
            dat  = 8'($urandom) & LIVE;
            p    = 8'($urandom);
            wr(A_MHI, mode[15:8]); wr(A_MLO, mode[7:0]);
            wr(A_DIR, dir); wr(A_DATA, dat); wr(A_EN, en);
            @(negedge clk) pin_in = p;
            settle(6);
            wr(A_FLAG, 8'hFF);
            eff = ((dir & dat) | (~dir & p)) & LIVE;
            rd(A_DATA, v); check("R4", "data view", {8'h0, v}, {8'h0, eff});
            check("R3", "oe", {8'h0, pin_oe}, {8'h0, dir});
            rd(A_FLAG, v); check("R5", "steady no flag", {8'h0, v}, 16'h0);
            check("R8", "rand level irq", {8'h0, irq}, {8'h0, en & level_mask(mode) & ~eff});
            p2 = 8'($urandom);
            @(negedge clk) pin_in = p2;
            settle(6);
            eff2 = ((dir & dat) | (~dir & p2)) & LIVE;
            ef   = exp_flags(mode, eff, eff2);
            rd(A_FLAG, v); check("R5", "rand flags", {8'h0, v}, {8'h0, ef});
            check("R7", "rand irq", {8'h0, irq},
                  {8'h0, en & (ef | (level_mask(mode) & ~eff2)) & LIVE});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule